// File: doc/BRIEF.md
# DFI read-data rate converter

This block sits between a PHY whose read-data path runs on a fast clock with a few wide phases and a memory controller that runs on a slower system clock and expects more, narrower phases. The fast clock runs RATIO times as fast as the slow clock, and its rising edges line up with the slow ones. Once in every slow period, the block takes a snapshot of the fast-side read data and read-valid. It then cuts each wide fast phase into RATIO narrow slow phases and presents the result on the slow side after a fixed pipeline delay.

The parameter READ_DELAY (0 to RATIO-1) chooses which fast cycle within the slow period is captured. This absorbs PHY read latencies that do not fall on a slow-clock boundary. When the latency grows past the last fast cycle, the integration instead adds a whole slow cycle of delay upstream and sets READ_DELAY back to 0. A fast-domain phase counter, cleared by the shared reset, marks the position of each fast cycle within the slow period.

Top module: `rdc_read_converter`

## Requirements
- R1: Slow lane i (i = j*RATIO + k) carries bits [k*SLOW_W +: SLOW_W] of fast phase j. The least significant slice goes to the lowest lane. With the default widths, fast phase 0 value 0x...2222_1111 gives 0x1111 on lane 0 and 0x2222 on lane 1.
- R2: The valid bit of fast phase j is copied onto every slow lane j*RATIO through j*RATIO+RATIO-1. Within such a group the slow valid bits are therefore all set or all clear.
- R3: Fast cycles in a slow period are numbered 0 to RATIO-1, and cycle 0 begins at the slow edge. Only the fast cycle whose number equals READ_DELAY is captured. Data and valid on the other fast cycles of that period have no effect on the outputs.
- R4: Data captured in slow period P appears on the slow outputs during slow period P+1+SLOW_STAGES. During period P+SLOW_STAGES the outputs do not yet show it.
- R5: Each capture is shown for exactly one slow period. Captures from consecutive periods follow each other with no gap and no repeat.
- R6: If the captured fast cycle has a fast valid bit clear, every slow lane of that phase group shows valid low.
- R7: While reset is asserted, and after release until new captures arrive, all slow data and valid outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast PHY-side clock, RATIO times the slow clock, rising edges aligned |
| clk_slow | input | 1 | Slow system clock |
| rst | input | 1 | Synchronous active-high reset, released just after an aligned slow edge |
| fast_rddata | input | FAST_PHASES*RATIO*SLOW_W | Fast-side read data, phase 0 in the low bits |
| fast_rddata_valid | input | FAST_PHASES | Fast-side read-valid, one bit per fast phase |
| slow_rddata | output | FAST_PHASES*RATIO*SLOW_W | Slow-side read data, lane 0 in the low bits |
| slow_rddata_valid | output | FAST_PHASES*RATIO | Slow-side read-valid, one bit per slow lane |

## Verification
The bench runs two instances side by side, one capturing the first fast cycle of the period and one capturing the last. It drives a different data and valid pattern on every fast cycle. A converter that captures the wrong cycle therefore shows another cycle's tag in its data, and one that captures at the period boundary without a transfer stage slips by a whole slow period. Valid patterns set on only one fast phase, or set on every cycle except the captured one, expose replication onto the wrong lane group and leaking of uncaptured valids. Checks one period before and one period after the expected slot catch a pipeline that is too short, too long, or that holds stale data.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
    // Width of a counter that holds values 0 .. n-1 (at least one bit).
    function automatic int cnt_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rdc_phase_counter.sv
module rdc_phase_counter #(
    parameter int RATIO = 4,
    localparam int CW = rdc_pkg::cnt_bits(RATIO)
) (
    input  logic          clk_fast,
    input  logic          rst,
    output logic [CW-1:0] cnt_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CW'(RATIO - 1)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_fast) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/rdc_capture.sv
module rdc_capture #(
    parameter int RATIO      = 4,
    parameter int DATA_W     = 128,
    parameter int VAL_W      = 2,
    parameter int READ_DELAY = 0,
    localparam int CW = rdc_pkg::cnt_bits(RATIO)
) (
    input  logic              clk_fast,
    input  logic              rst,
    input  logic [CW-1:0]     cnt_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [VAL_W-1:0]  valid_i,
    output logic [DATA_W-1:0] hold_data_o,
    output logic [VAL_W-1:0]  hold_valid_o,
    output logic [DATA_W-1:0] xfer_data_o,
    output logic [VAL_W-1:0]  xfer_valid_o
);
    typedef struct packed {
        logic [DATA_W-1:0] hold_data;
        logic [VAL_W-1:0]  hold_valid;
        logic [DATA_W-1:0] xfer_data;
        logic [VAL_W-1:0]  xfer_valid;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Snapshot the selected fast cycle of the slow period.
        if (cnt_i == CW'(READ_DELAY)) begin
            st_d.hold_data  = data_i;
            st_d.hold_valid = valid_i;
        end
        // Hand over one fast cycle after the slow edge, so the slow side
        // always samples a value that settled a full period earlier.
        if (cnt_i == '0) begin
            st_d.xfer_data  = st_q.hold_data;
            st_d.xfer_valid = st_q.hold_valid;
        end
    end

    always_ff @(posedge clk_fast) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_data_o  = st_q.hold_data;
    assign hold_valid_o = st_q.hold_valid;
    assign xfer_data_o  = st_q.xfer_data;
    assign xfer_valid_o = st_q.xfer_valid;
endmodule

// File: rtl/rdc_splitter.sv
module rdc_splitter #(
    parameter int FAST_PHASES = 2,
    parameter int RATIO       = 4,
    parameter int SLOW_W      = 16,
    localparam int FAST_W      = SLOW_W * RATIO,
    localparam int SLOW_PHASES = FAST_PHASES * RATIO
) (
    input  logic [FAST_PHASES*FAST_W-1:0] fast_data_i,
    input  logic [FAST_PHASES-1:0]        fast_valid_i,
    output logic [SLOW_PHASES*SLOW_W-1:0] slow_data_o,
    output logic [SLOW_PHASES-1:0]        slow_valid_o
);
    for (genvar j = 0; j < FAST_PHASES; j++) begin : g_phase
        for (genvar k = 0; k < RATIO; k++) begin : g_slice
            assign slow_data_o[(j*RATIO + k)*SLOW_W +: SLOW_W] =
                fast_data_i[j*FAST_W + k*SLOW_W +: SLOW_W];
            assign slow_valid_o[j*RATIO + k] = fast_valid_i[j];
        end
    end
endmodule

// File: rtl/rdc_slow_pipe.sv
module rdc_slow_pipe #(
    parameter int STAGES = 2,
    parameter int DATA_W = 128,
    parameter int VAL_W  = 8
) (
    input  logic              clk_slow,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_i,
    input  logic [VAL_W-1:0]  valid_i,
    output logic [DATA_W-1:0] data_o,
    output logic [VAL_W-1:0]  valid_o
);
    typedef struct packed {
        logic [STAGES-1:0][DATA_W-1:0] data;
        logic [STAGES-1:0][VAL_W-1:0]  valid;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.data[0]  = data_i;
        st_d.valid[0] = valid_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.data[s]  = st_q.data[s-1];
            st_d.valid[s] = st_q.valid[s-1];
        end
    end

    always_ff @(posedge clk_slow) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data[STAGES-1];
    assign valid_o = st_q.valid[STAGES-1];
endmodule

// File: rtl/rdc_read_converter.sv
module rdc_read_converter #(
    parameter int RATIO       = 4,
    parameter int FAST_PHASES = 2,
    parameter int SLOW_W      = 16,
    parameter int READ_DELAY  = 0,
    parameter int SLOW_STAGES = 2,
    localparam int SLOW_PHASES = FAST_PHASES * RATIO,
    localparam int BUS_W       = SLOW_PHASES * SLOW_W,
    localparam int CW          = rdc_pkg::cnt_bits(RATIO)
) (
    input  logic                   clk_fast,
    input  logic                   clk_slow,
    input  logic                   rst,
    input  logic [BUS_W-1:0]       fast_rddata,
    input  logic [FAST_PHASES-1:0] fast_rddata_valid,
    output logic [BUS_W-1:0]       slow_rddata,
    output logic [SLOW_PHASES-1:0] slow_rddata_valid
);
    logic [CW-1:0]          cnt_w;
    logic [BUS_W-1:0]       hold_data_w;
    logic [FAST_PHASES-1:0] hold_valid_w;
    logic [BUS_W-1:0]       xfer_data_w;
    logic [FAST_PHASES-1:0] xfer_valid_w;
    logic [BUS_W-1:0]       split_data_w;
    logic [SLOW_PHASES-1:0] split_valid_w;

    rdc_phase_counter #(.RATIO(RATIO)) i_counter (
        .clk_fast (clk_fast),
        .rst      (rst),
        .cnt_o    (cnt_w)
    );

    rdc_capture #(
        .RATIO      (RATIO),
        .DATA_W     (BUS_W),
        .VAL_W      (FAST_PHASES),
        .READ_DELAY (READ_DELAY)
    ) i_capture (
        .clk_fast     (clk_fast),
        .rst          (rst),
        .cnt_i        (cnt_w),
        .data_i       (fast_rddata),
        .valid_i      (fast_rddata_valid),
        .hold_data_o  (hold_data_w),
        .hold_valid_o (hold_valid_w),
        .xfer_data_o  (xfer_data_w),
        .xfer_valid_o (xfer_valid_w)
    );

    rdc_splitter #(
        .FAST_PHASES (FAST_PHASES),
        .RATIO       (RATIO),
        .SLOW_W      (SLOW_W)
    ) i_splitter (
        .fast_data_i  (xfer_data_w),
        .fast_valid_i (xfer_valid_w),
        .slow_data_o  (split_data_w),
        .slow_valid_o (split_valid_w)
    );

    rdc_slow_pipe #(
        .STAGES (SLOW_STAGES),
        .DATA_W (BUS_W),
        .VAL_W  (SLOW_PHASES)
    ) i_slow_pipe (
        .clk_slow (clk_slow),
        .rst      (rst),
        .data_i   (split_data_w),
        .valid_i  (split_valid_w),
        .data_o   (slow_rddata),
        .valid_o  (slow_rddata_valid)
    );
endmodule

// File: rtl/rdc_read_converter_chk.sv
module rdc_read_converter_chk #(
    parameter int RATIO       = 4,
    parameter int FAST_PHASES = 2,
    parameter int READ_DELAY  = 0,
    parameter int DATA_W      = 128,
    localparam int SLOW_PHASES = FAST_PHASES * RATIO,
    localparam int CW          = rdc_pkg::cnt_bits(RATIO)
) (
    input logic                   clk_fast,
    input logic                   clk_slow,
    input logic                   rst,
    input logic [CW-1:0]          cnt,
    input logic [DATA_W-1:0]      hold_data,
    input logic [FAST_PHASES-1:0] hold_valid,
    input logic [SLOW_PHASES-1:0] slow_valid
);
    // R3: phase counter wraps at the end of the slow period
    assert_cnt_wrap_R3: assert property (@(posedge clk_fast) disable iff (rst)
        (cnt == CW'(RATIO - 1)) |=> (cnt == '0));

    // R3: phase counter advances by one on every other fast cycle
    assert_cnt_step_R3: assert property (@(posedge clk_fast) disable iff (rst)
        (cnt != CW'(RATIO - 1)) |=> (cnt == $past(cnt) + CW'(1)));

    // R3: the snapshot only changes after the selected fast cycle
    assert_hold_stable_R3: assert property (@(posedge clk_fast) disable iff (rst)
        (cnt != CW'(READ_DELAY)) |=> ($stable(hold_data) && $stable(hold_valid)));

    // R2: each lane group shows its valid all set or all clear
    for (genvar j = 0; j < FAST_PHASES; j++) begin : g_grp
        assert_valid_group_R2: assert property (@(posedge clk_slow) disable iff (rst)
            ($countones(slow_valid[j*RATIO +: RATIO]) == 0) ||
            ($countones(slow_valid[j*RATIO +: RATIO]) == RATIO));
    end

    // R7: reset clears every slow valid
    assert_reset_clear_R7: assert property (@(posedge clk_slow)
        rst |=> (slow_valid == '0));
endmodule

bind rdc_read_converter rdc_read_converter_chk #(
    .RATIO       (RATIO),
    .FAST_PHASES (FAST_PHASES),
    .READ_DELAY  (READ_DELAY),
    .DATA_W      (BUS_W)
) i_chk (
    .clk_fast   (clk_fast),
    .clk_slow   (clk_slow),
    .rst        (rst),
    .cnt        (cnt_w),
    .hold_data  (hold_data_w),
    .hold_valid (hold_valid_w),
    .slow_valid (slow_rddata_valid)
);

// File: tb/test_rdc_read_converter.sv
module test_rdc_read_converter;
    localparam int R  = 4;
    localparam int FP = 2;
    localparam int SW = 16;
    localparam int S  = 2;
    localparam int SP = FP * R;
    localparam int BW = SP * SW;

    logic          clk_fast = 1'b0;
    logic          clk_slow = 1'b0;
    logic          rst = 1'b1;
    logic [BW-1:0] fd = '0;
    logic [FP-1:0] fv = '0;
    logic [BW-1:0] so_a, so_b;
    logic [SP-1:0] sv_a, sv_b;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Rising edges of both clocks coincide every R fast cycles.
    initial begin
        #5;
        forever begin clk_fast = 1'b1; #5; clk_fast = 1'b0; #5; end
    end
    initial begin
        #5;
        forever begin clk_slow = 1'b1; #(5*R); clk_slow = 1'b0; #(5*R); end
    end

    rdc_read_converter #(.RATIO(R), .FAST_PHASES(FP), .SLOW_W(SW),
                         .READ_DELAY(0), .SLOW_STAGES(S)) i_rdc_read_converter (
        .clk_fast (clk_fast), .clk_slow (clk_slow), .rst (rst),
        .fast_rddata (fd), .fast_rddata_valid (fv),
        .slow_rddata (so_a), .slow_rddata_valid (sv_a)
    );

    rdc_read_converter #(.RATIO(R), .FAST_PHASES(FP), .SLOW_W(SW),
                         .READ_DELAY(R-1), .SLOW_STAGES(S)) i_rdc_read_converter_late (
        .clk_fast (clk_fast), .clk_slow (clk_slow), .rst (rst),
        .fast_rddata (fd), .fast_rddata_valid (fv),
        .slow_rddata (so_b), .slow_rddata_valid (sv_b)
    );

    // Lane i word tags the seed, the fast cycle and the lane.
    function automatic logic [BW-1:0] pat(input logic [7:0] seed, input int k);
        logic [BW-1:0] r;
        for (int i = 0; i < SP; i++) r[i*SW +: SW] = {seed, 4'(k), 4'(i)};
        return r;
    endfunction

    function automatic logic [SP-1:0] rep(input logic [FP-1:0] m);
        logic [SP-1:0] r;
        for (int i = 0; i < SP; i++) r[i] = m[i / R];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // R7: outputs are zero during and right after reset.
    task automatic test_reset();
        repeat (3) @(posedge clk_slow);
        #3;
        chk("R7 valid in reset a", BW'(sv_a), '0);
        chk("R7 data in reset a", so_a, '0);
        @(posedge clk_slow);
        #1 rst = 1'b0;
        #2;
        chk("R7 valid after release b", BW'(sv_b), '0);
        chk("R7 data after release b", so_b, '0);
        repeat (2) @(posedge clk_slow);
        #3;
        chk("R7 valid idle a", BW'(sv_a), '0);
        chk("R7 valid idle b", BW'(sv_b), '0);
    endtask

    // Drive one slow period with a distinct pattern per fast cycle and
    // check both instances one period early, on time and one period late.
    task automatic run_period(input string tag, input logic [7:0] seed,
                              input logic [R-1:0][FP-1:0] vms);
        @(posedge clk_slow);
        for (int k = 0; k < R; k++) begin
            @(negedge clk_fast);
            fd = pat(seed, k);
            fv = vms[k];
        end
        @(negedge clk_fast);
        fd = '0;
        fv = '0;
        repeat (S - 1) @(posedge clk_slow);
        #3;
        chk({"R4 early valid a ", tag}, BW'(sv_a), '0);
        chk({"R4 early valid b ", tag}, BW'(sv_b), '0);
        @(posedge clk_slow);
        #3;
        chk({"R1 data a ", tag}, so_a, pat(seed, 0));
        chk({"R3 data b ", tag}, so_b, pat(seed, R - 1));
        chk({tag, " valid a"}, BW'(sv_a), BW'(rep(vms[0])));
        chk({tag, " valid b"}, BW'(sv_b), BW'(rep(vms[R-1])));
        @(posedge clk_slow);
        #3;
        chk({"R5 late valid a ", tag}, BW'(sv_a), '0);
        chk({"R5 late valid b ", tag}, BW'(sv_b), '0);
    endtask

    // R5: two consecutive captured periods follow with no gap or repeat.
    task automatic back_to_back(input logic [7:0] sa, input logic [7:0] sb);
        @(posedge clk_slow);
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < R; k++) begin
                @(negedge clk_fast);
                fd = pat((p == 0) ? sa : sb, k);
                fv = '1;
            end
        end
        @(negedge clk_fast);
        fd = '0;
        fv = '0;
        repeat (S - 1) @(posedge clk_slow);
        #3;
        chk("R5 first a", so_a, pat(sa, 0));
        chk("R5 first b", so_b, pat(sa, R - 1));
        @(posedge clk_slow);
        #3;
        chk("R5 second a", so_a, pat(sb, 0));
        chk("R5 second b", so_b, pat(sb, R - 1));
        chk("R5 second valid a", BW'(sv_a), BW'({SP{1'b1}}));
        @(posedge clk_slow);
        #3;
        chk("R5 drained valid a", BW'(sv_a), '0);
        chk("R5 drained valid b", BW'(sv_b), '0);
    endtask

    initial begin
        test_reset();
        // all phases valid on every cycle
        run_period("R2 all", 8'hA1, {2'b11, 2'b11, 2'b11, 2'b11});
        // distinct single-phase valids: cycle 0 phase 0, cycle 3 phase 1
        run_period("R2 split", 8'hB2, {2'b10, 2'b00, 2'b10, 2'b01});
        // valid everywhere except cycle 0
        run_period("R6 skip0", 8'hC3, {2'b11, 2'b11, 2'b11, 2'b00});
        // no valid at all
        run_period("R6 none", 8'hD4, {2'b00, 2'b00, 2'b00, 2'b00});
        // valid only on cycle 1 and 2: neither instance captures it
        run_period("R3 middle", 8'hE5, {2'b00, 2'b11, 2'b11, 2'b00});
        back_to_back(8'h16, 8'h27);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule